// File: doc/BRIEF.md
# Tiled Texture Box Transfer Sequencer

This block turns a request to move a rectangular region of a texture into a stream of row copy commands. The region is measured in pixels, but it must sit on microtile boundaries. A microtile always holds 64 bytes, and its shape in pixels depends on the bytes per pixel. For every row of every microtile inside the region, the block emits one command. Each command carries a byte address on the tiled side, a byte address on the linear side and a byte count. A downstream copy engine accepts the commands through a valid/ready handshake and performs the actual data movement.

Two tiled layouts are supported. The first keeps microtiles in plain raster order. The second is hierarchical:
- 1 KiB subtiles hold 4x4 microtiles.
- 4 KiB tiles hold 2x2 subtiles, and the subtile order inside a tile depends on the parity of the tile row.
- Tile rows run in a serpentine pattern: left to right on even rows, right to left on odd rows.

A direction flag (load or store) travels with every command; it does not change any address. A separate combinational helper tells software-side logic which layout a mip level of a given size would use.

Top module: `tile_box_seq`

## Requirements
- R1: The microtile is 8x8 pixels at 1 byte per pixel, 8x4 at 2, 4x4 at 4 and 2x4 at 8 (width x height). Each command moves one microtile row of 64 / height bytes: 8 bytes at 1 byte per pixel, 16 bytes otherwise.
- R2: A start with a bytes-per-pixel value other than 1, 2, 4 or 8 raises `err` for exactly one cycle, in the cycle after start. No command and no `done` follow.
- R3: A start whose box x or width is not a multiple of the microtile width, or whose box y or height is not a multiple of the microtile height, raises `err` the same way and issues nothing.
- R4: Microtiles are visited in raster order over the box, rows before columns. The rows of one microtile are issued consecutively. On the tiled side, row k of a microtile is at the microtile base plus k times the row byte count.
- R5: The linear address of row k of box microtile (x, y) is (y·uh + k)·linear_stride + x·uw·bpp, where uw is the microtile width and uh is the microtile height.
- R6: With `layout_t` = 0 (raster microtiles), the tiled base of microtile (x, y) is (ys + y)·tiled_stride·uh + (xs + x)·64. Here xs and ys are the box start in microtiles.
- R7: With `layout_t` = 1 (hierarchical), let U = tiled_stride / bpp / uw and T = U / 8. For absolute microtile (X, Y), the tile row is Y/8. The tile column is X/8, mirrored to T − 1 − X/8 on odd tile rows. The tiled base is 4096·(row·T + col) + 1024·S + 64·(4·(Y mod 4) + X mod 4). The subtile index i is 2·bit2(Y) + bit2(X), and S is {0,3,1,2}[i] on even tile rows and {2,1,3,0}[i] on odd ones.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command outputs hold their values.
- R9: `done` pulses for one cycle, in the cycle after the last command is accepted.
- R10: A legal, aligned start with zero width or zero height issues no command and pulses `done` in the cycle after start.
- R11: `lvl_is_lt` is 1 when `lvl_w` ≤ 4·uw or `lvl_h` ≤ 4·uh for the current `bpp`, and 0 otherwise.
- R12: A start while a box is being walked is ignored, even with an illegal configuration: the command stream, `err` and `done` are unaffected.
- R13: `cmd_store` carries the `store` input sampled at start for every command of that box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a box walk (honoured only when idle) |
| store | input | 1 | 0 = load from tiled, 1 = store to tiled |
| layout_t | input | 1 | 0 = raster microtiles, 1 = hierarchical tiles |
| bpp | input | 4 | Bytes per pixel (1, 2, 4 or 8) |
| box_x | input | CW | Box left edge in pixels |
| box_y | input | CW | Box top edge in pixels |
| box_w | input | CW | Box width in pixels |
| box_h | input | CW | Box height in pixels |
| tiled_stride | input | SW | Tiled-side stride in bytes |
| linear_stride | input | SW | Linear-side stride in bytes |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_valid | output | 1 | Command present |
| cmd_store | output | 1 | Direction of this command |
| cmd_tiled_addr | output | AW | Tiled-side byte address |
| cmd_linear_addr | output | AW | Linear-side byte address |
| cmd_len | output | 5 | Bytes to move |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle configuration error pulse |
| lvl_w | input | CW | Level width for layout classification |
| lvl_h | input | CW | Level height for layout classification |
| lvl_is_lt | output | 1 | Level would use raster microtiles |

## Verification
Two functions can meet in one cycle: a box walk in progress and a fresh start request. The start request might trigger the error pulse or a new walk. The bench provokes this by raising start mid-walk with a misaligned box x under a stalling ready pattern. It judges the outcome by requiring that `err` never rises, that the full command list still matches the model in order, and that exactly one `done` arrives, right after the final accepted row. Stalls are also checked against the hold rule, and the `done` pulse is timed against the last handshake.

// File: rtl/tbx_pkg.sv
package tbx_pkg;

    typedef enum logic [0:0] {LAY_RASTER = 1'b0, LAY_HIER = 1'b1} layout_e;
    typedef enum logic [0:0] {DIR_LOAD = 1'b0, DIR_STORE = 1'b1} dir_e;

    typedef struct packed {
        logic [3:0] bpp;
        layout_e    lay;
        dir_e       dir;
    } mode_t;

    localparam int UTILE_BYTES = 64;
    localparam int UTILE_LOG2  = 6;

    function automatic logic bpp_legal(input logic [3:0] b);
        return (b == 4'd1) || (b == 4'd2) || (b == 4'd4) || (b == 4'd8);
    endfunction

    // log2 of microtile width in pixels
    function automatic logic [1:0] ut_wlog(input logic [3:0] b);
        case (b)
            4'd4:    return 2'd2;
            4'd8:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // log2 of microtile height in pixel rows
    function automatic logic [1:0] ut_hlog(input logic [3:0] b);
        return (b == 4'd1) ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [3:0] ut_w(input logic [3:0] b);
        return 4'd1 << ut_wlog(b);
    endfunction

    function automatic logic [3:0] ut_h(input logic [3:0] b);
        return 4'd1 << ut_hlog(b);
    endfunction

    // log2 of bytes in one microtile row (64 / height)
    function automatic logic [2:0] row_log(input logic [3:0] b);
        return 3'(UTILE_LOG2) - {1'b0, ut_hlog(b)};
    endfunction

endpackage

// File: rtl/tbx_cfg_check.sv
module tbx_cfg_check
    import tbx_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [3:0]    bpp,
    input  logic [CW-1:0] box_x,
    input  logic [CW-1:0] box_y,
    input  logic [CW-1:0] box_w,
    input  logic [CW-1:0] box_h,
    output logic          cfg_ok,
    output logic          cfg_empty,
    output logic [CW-1:0] xs_u,
    output logic [CW-1:0] ys_u,
    output logic [CW-1:0] nx_u,
    output logic [CW-1:0] ny_u
);

    logic [CW-1:0] wmask, hmask;
    logic          aligned;

    always_comb begin
        wmask   = CW'(ut_w(bpp)) - CW'(1);
        hmask   = CW'(ut_h(bpp)) - CW'(1);
        aligned = ((box_x & wmask) == '0) && ((box_w & wmask) == '0) &&
                  ((box_y & hmask) == '0) && ((box_h & hmask) == '0);
        cfg_ok    = bpp_legal(bpp) && aligned;
        xs_u      = box_x >> ut_wlog(bpp);
        ys_u      = box_y >> ut_hlog(bpp);
        nx_u      = box_w >> ut_wlog(bpp);
        ny_u      = box_h >> ut_hlog(bpp);
        cfg_empty = (nx_u == '0) || (ny_u == '0);
    end

endmodule

// File: rtl/tbx_t_addr.sv
module tbx_t_addr #(
    parameter int CW = 16,
    parameter int SW = 20,
    parameter int AW = 32
) (
    input  logic [CW-1:0] ux_abs,
    input  logic [CW-1:0] uy_abs,
    input  logic [SW-1:0] tiled_stride,
    input  logic [2:0]    row_lg,
    output logic [AW-1:0] offset
);

    localparam int TILE_LG  = 12;
    localparam int STILE_LG = 10;
    localparam int UT_LG    = 6;
    localparam int UPT_LG   = 3;   // microtiles per tile side, log2

    logic [SW-1:0] ut_stride, tile_stride;
    logic [CW-1:0] tile_x, tile_y, tx_eff;
    logic          odd_row;
    logic [1:0]    st_idx, st_slot;

    always_comb begin
        ut_stride   = tiled_stride >> row_lg;
        tile_stride = ut_stride >> UPT_LG;
        tile_x      = ux_abs >> UPT_LG;
        tile_y      = uy_abs >> UPT_LG;
        odd_row     = tile_y[0];
        tx_eff      = odd_row ? (CW'(tile_stride) - tile_x - CW'(1)) : tile_x;
        st_idx      = {uy_abs[2], ux_abs[2]};
        if (odd_row) begin
            case (st_idx)
                2'd0:    st_slot = 2'd2;
                2'd1:    st_slot = 2'd1;
                2'd2:    st_slot = 2'd3;
                default: st_slot = 2'd0;
            endcase
        end else begin
            case (st_idx)
                2'd0:    st_slot = 2'd0;
                2'd1:    st_slot = 2'd3;
                2'd2:    st_slot = 2'd1;
                default: st_slot = 2'd2;
            endcase
        end
        offset = ((AW'(tile_y) * AW'(tile_stride) + AW'(tx_eff)) << TILE_LG)
               + (AW'(st_slot) << STILE_LG)
               + (AW'({uy_abs[1:0], ux_abs[1:0]}) << UT_LG);
    end

endmodule

// File: rtl/tbx_walker.sv
module tbx_walker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_ok,
    input  logic          cfg_empty,
    input  logic [CW-1:0] nx,
    input  logic [CW-1:0] ny,
    input  logic [3:0]    rows,
    input  logic          cmd_ready,
    output logic          busy,
    output logic          launch,
    output logic [CW-1:0] ux,
    output logic [CW-1:0] uy,
    output logic [3:0]    r,
    output logic          done,
    output logic          err
);

    logic last_r, last_x, last_y;

    assign last_r = (r == rows - 4'd1);
    assign last_x = (ux == nx - CW'(1));
    assign last_y = (uy == ny - CW'(1));
    assign launch = start && !busy && cfg_ok && !cfg_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ux   <= '0;
            uy   <= '0;
            r    <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (!cfg_ok) begin
                        err <= 1'b1;
                    end else if (cfg_empty) begin
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                        ux   <= '0;
                        uy   <= '0;
                        r    <= '0;
                    end
                end
            end else if (cmd_ready) begin
                if (!last_r) begin
                    r <= r + 4'd1;
                end else begin
                    r <= '0;
                    if (!last_x) begin
                        ux <= ux + CW'(1);
                    end else begin
                        ux <= '0;
                        if (!last_y) begin
                            uy <= uy + CW'(1);
                        end else begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !done));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_ready && !last_r) |=> (busy && r == $past(r) + 4'd1 && $stable(ux) && $stable(uy)));

    // R4
    in_box_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ux < nx && uy < ny && r < rows));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !cmd_ready) |=> (busy && !err && $stable(ux) && $stable(uy) && $stable(r)));

endmodule

// File: rtl/tile_box_seq.sv
module tile_box_seq
    import tbx_pkg::*;
#(
    parameter int CW = 16,
    parameter int SW = 20,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          store,
    input  logic          layout_t,
    input  logic [3:0]    bpp,
    input  logic [CW-1:0] box_x,
    input  logic [CW-1:0] box_y,
    input  logic [CW-1:0] box_w,
    input  logic [CW-1:0] box_h,
    input  logic [SW-1:0] tiled_stride,
    input  logic [SW-1:0] linear_stride,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output logic          cmd_store,
    output logic [AW-1:0] cmd_tiled_addr,
    output logic [AW-1:0] cmd_linear_addr,
    output logic [4:0]    cmd_len,
    output logic          done,
    output logic          err,
    input  logic [CW-1:0] lvl_w,
    input  logic [CW-1:0] lvl_h,
    output logic          lvl_is_lt
);

    localparam int LVL_W = CW + 8;

    logic          cfg_ok, cfg_empty, launch, busy;
    logic [CW-1:0] xs_l, ys_l, nx_l, ny_l;      // live
    logic [CW-1:0] xs_q, ys_q, nx_q, ny_q;      // latched
    logic [SW-1:0] tstr_q, lstr_q;
    mode_t         mode_q;
    logic [CW-1:0] ux, uy;
    logic [3:0]    r, rows;
    logic [2:0]    rlg;
    logic [AW-1:0] t_off, lt_base, tiled_base;

    tbx_cfg_check #(.CW(CW)) u_chk (
        .bpp(bpp), .box_x(box_x), .box_y(box_y), .box_w(box_w), .box_h(box_h),
        .cfg_ok(cfg_ok), .cfg_empty(cfg_empty),
        .xs_u(xs_l), .ys_u(ys_l), .nx_u(nx_l), .ny_u(ny_l)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{bpp: 4'd4, lay: LAY_RASTER, dir: DIR_LOAD};
            xs_q   <= '0;
            ys_q   <= '0;
            nx_q   <= '0;
            ny_q   <= '0;
            tstr_q <= '0;
            lstr_q <= '0;
        end else if (launch) begin
            mode_q <= '{bpp: bpp, lay: layout_e'(layout_t), dir: dir_e'(store)};
            xs_q   <= xs_l;
            ys_q   <= ys_l;
            nx_q   <= nx_l;
            ny_q   <= ny_l;
            tstr_q <= tiled_stride;
            lstr_q <= linear_stride;
        end
    end

    assign rows = ut_h(mode_q.bpp);
    assign rlg  = row_log(mode_q.bpp);

    tbx_walker #(.CW(CW)) u_walk (
        .clk(clk), .rst(rst), .start(start), .cfg_ok(cfg_ok), .cfg_empty(cfg_empty),
        .nx(nx_q), .ny(ny_q), .rows(rows), .cmd_ready(cmd_ready),
        .busy(busy), .launch(launch), .ux(ux), .uy(uy), .r(r),
        .done(done), .err(err)
    );

    tbx_t_addr #(.CW(CW), .SW(SW), .AW(AW)) u_taddr (
        .ux_abs(xs_q + ux), .uy_abs(ys_q + uy),
        .tiled_stride(tstr_q), .row_lg(rlg), .offset(t_off)
    );

    always_comb begin
        lt_base    = (AW'(ys_q) + AW'(uy)) * AW'(tstr_q) * AW'(rows)
                   + ((AW'(xs_q) + AW'(ux)) << UTILE_LOG2);
        tiled_base = (mode_q.lay == LAY_HIER) ? t_off : lt_base;
        cmd_tiled_addr  = tiled_base + (AW'(r) << rlg);
        cmd_linear_addr = (AW'(uy) * AW'(rows) + AW'(r)) * AW'(lstr_q)
                        + (AW'(ux) << rlg);
        cmd_len   = 5'd1 << rlg;
        cmd_valid = busy;
        cmd_store = (mode_q.dir == DIR_STORE);
    end

    assign lvl_is_lt = (LVL_W'(lvl_w) <= (LVL_W'(ut_w(bpp)) << 2)) ||
                       (LVL_W'(lvl_h) <= (LVL_W'(ut_h(bpp)) << 2));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_tiled_addr) &&
                                       $stable(cmd_linear_addr) && $stable(cmd_len)));

    // R1
    len_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len == 5'd8 || cmd_len == 5'd16));

    // R13
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(cmd_valid)) |-> $stable(cmd_store));

endmodule

// File: tb/tb_tile_box_seq.sv
module tb_tile_box_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int SW = 20;
    localparam int AW = 32;
    localparam int MAXC = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, store = 1'b0, layout_t = 1'b0;
    logic [3:0]    bpp = 4'd4;
    logic [CW-1:0] box_x = '0, box_y = '0, box_w = '0, box_h = '0;
    logic [SW-1:0] tiled_stride = '0, linear_stride = '0;
    logic          cmd_ready = 1'b0;
    logic          cmd_valid, cmd_store, done, err, lvl_is_lt;
    logic [AW-1:0] cmd_tiled_addr, cmd_linear_addr;
    logic [4:0]    cmd_len;
    logic [CW-1:0] lvl_w = '0, lvl_h = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int exp_t [MAXC];
    int exp_l [MAXC];
    int exp_n;
    int exp_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_box_seq #(.CW(CW), .SW(SW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .store(store), .layout_t(layout_t),
        .bpp(bpp), .box_x(box_x), .box_y(box_y), .box_w(box_w), .box_h(box_h),
        .tiled_stride(tiled_stride), .linear_stride(linear_stride),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_tiled_addr(cmd_tiled_addr), .cmd_linear_addr(cmd_linear_addr),
        .cmd_len(cmd_len), .done(done), .err(err),
        .lvl_w(lvl_w), .lvl_h(lvl_h), .lvl_is_lt(lvl_is_lt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mw(input int b);
        if (b == 4) return 4;
        if (b == 8) return 2;
        return 8;
    endfunction

    function automatic int mh(input int b);
        return (b == 1) ? 8 : 4;
    endfunction

    // R7 reference
    function automatic int hier_off(input int x, input int y, input int ustride);
        int ts, tx, ty, idx, slot;
        ts = ustride / 8;
        tx = x / 8;
        ty = y / 8;
        if (ty % 2 == 1) tx = ts - tx - 1;
        idx = 2 * ((y / 4) % 2) + ((x / 4) % 2);
        if (ty % 2 == 1) begin
            case (idx) 0: slot = 2; 1: slot = 1; 2: slot = 3; default: slot = 0; endcase
        end else begin
            case (idx) 0: slot = 0; 1: slot = 3; 2: slot = 1; default: slot = 2; endcase
        end
        return 4096 * (ty * ts + tx) + 1024 * slot + 64 * (4 * (y % 4) + (x % 4));
    endfunction

    task automatic build_expect();
        int uw, uh, rb, xs, ys, nx, ny, base, b;
        b  = int'(bpp);
        uw = mw(b);
        uh = mh(b);
        rb = 64 / uh;
        xs = int'(box_x) / uw;
        ys = int'(box_y) / uh;
        nx = int'(box_w) / uw;
        ny = int'(box_h) / uh;
        exp_len = rb;
        exp_n = 0;
        for (int y = 0; y < ny; y++) begin
            for (int x = 0; x < nx; x++) begin
                if (layout_t)
                    base = hier_off(xs + x, ys + y, int'(tiled_stride) / b / uw);
                else
                    base = (ys + y) * int'(tiled_stride) * uh + (xs + x) * 64;
                for (int k = 0; k < uh; k++) begin
                    exp_t[exp_n] = base + k * rb;
                    exp_l[exp_n] = (y * uh + k) * int'(linear_stride) + x * uw * b;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic set_box(input bit st, input bit lay, input int b,
                           input int x, input int y, input int w, input int h,
                           input int ts, input int ls);
        store = st; layout_t = lay; bpp = 4'(b);
        box_x = CW'(x); box_y = CW'(y); box_w = CW'(w); box_h = CW'(h);
        tiled_stride = SW'(ts); linear_stride = SW'(ls);
    endtask

    // Walks one box and compares every accepted command with the model.
    // stall: ready low every third cycle; poke: restart attempt mid-walk.
    task automatic run_box(input string req_t, input bit stall, input bit poke);
        int idx = 0, cyc = 0, mism = 0, hold_bad = 0, n_done = 0, saw_err = 0;
        bit acc_prev = 0, stalled = 0, done_timed = 0;
        logic [AW-1:0] st_t, st_l;
        logic [CW-1:0] saved_x;
        bit saved_st;
        build_expect();
        saved_x = box_x;
        saved_st = store;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cyc < 2000) begin
            cmd_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (poke && cyc == 2) begin start = 1'b1; box_x = saved_x + CW'(1); end
            if (poke && cyc == 3) begin start = 1'b0; box_x = saved_x; end
            #1;
            if (err) saw_err++;
            if (stalled) begin
                if (!cmd_valid || cmd_tiled_addr != st_t || cmd_linear_addr != st_l) hold_bad++;
            end
            stalled = 0;
            if (done) begin
                n_done++;
                done_timed = acc_prev && (idx == exp_n);
                break;
            end
            acc_prev = 0;
            if (cmd_valid) begin
                if (idx >= exp_n) begin
                    mism++;
                end else if (cmd_ready) begin
                    chk(cmd_tiled_addr == AW'(exp_t[idx]), req_t, $sformatf("tiled addr #%0d", idx),
                        cmd_tiled_addr, exp_t[idx]);
                    chk(cmd_linear_addr == AW'(exp_l[idx]), "R5", $sformatf("linear addr #%0d", idx),
                        cmd_linear_addr, exp_l[idx]);
                    if (cmd_len != 5'(exp_len) || cmd_store != saved_st) mism++;
                    idx++;
                    acc_prev = 1;
                end else begin
                    stalled = 1;
                    st_t = cmd_tiled_addr;
                    st_l = cmd_linear_addr;
                end
            end
            cyc++;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        // R1 R13 row length and direction on every command
        chk(mism == 0, "R1", "len/dir mismatches", mism, 0);
        // R4 count in raster order
        chk(idx == exp_n, "R4", "commands accepted", idx, exp_n);
        // R9 done right after last accept
        chk(done_timed, "R9", "done timing", done_timed, 1);
        if (stall) chk(hold_bad == 0, "R8", "stall hold violations", hold_bad, 0);
        if (poke) chk(saw_err == 0 && n_done == 1, "R12", "err during busy start", saw_err, 0);
        @(negedge clk);
        #1;
        chk(!done && !cmd_valid, "R9", "done single pulse", done, 0);
    endtask

    task automatic run_err(input string req);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(err == 1'b1 && !cmd_valid && !done, req, "err pulse", err, 1);
        @(negedge clk);
        #1;
        chk(err == 1'b0 && !cmd_valid && !done, req, "err clears, no cmd", cmd_valid, 0);
    endtask

    task automatic run_empty();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done == 1'b1 && !cmd_valid && !err, "R10", "empty box done", done, 1);
        @(negedge clk);
        #1;
        chk(done == 1'b0 && !cmd_valid, "R10", "empty box no cmd", cmd_valid, 0);
    endtask

    task automatic run_class(input int b, input int w, input int h, input bit exp);
        bpp = 4'(b); lvl_w = CW'(w); lvl_h = CW'(h);
        #1;
        chk(lvl_is_lt == exp, "R11", $sformatf("class bpp%0d %0dx%0d", b, w, h), lvl_is_lt, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!cmd_valid && !done && !err, "R9", "reset quiet", cmd_valid, 0);

        // R6 raster microtiles, 4 B/px
        set_box(0, 0, 4, 4, 4, 8, 8, 64, 32);
        run_box("R6", 0, 0);
        // R6 R8 R12 R13 raster, 2 B/px, store, stalls, restart poke
        set_box(1, 0, 2, 8, 4, 16, 8, 128, 32);
        run_box("R6", 1, 1);
        // R7 hierarchical, 4 B/px, crosses tiles and odd tile rows
        set_box(0, 1, 4, 28, 28, 8, 40, 256, 64);
        run_box("R7", 0, 0);
        // R7 hierarchical, 8 B/px
        set_box(0, 1, 8, 4, 8, 8, 16, 128, 64);
        run_box("R7", 1, 0);
        // R7 R1 hierarchical, 1 B/px, store
        set_box(1, 1, 1, 56, 56, 16, 16, 128, 16);
        run_box("R7", 1, 0);

        // R2 illegal bytes per pixel
        set_box(0, 0, 3, 0, 0, 8, 8, 64, 32);
        run_err("R2");
        // R3 misaligned x at 4 B/px
        set_box(0, 0, 4, 2, 0, 8, 8, 64, 32);
        run_err("R3");
        // R3 misaligned height at 1 B/px
        set_box(0, 0, 1, 0, 0, 8, 12, 64, 32);
        run_err("R3");
        // R10 zero width
        set_box(0, 0, 4, 4, 4, 0, 8, 64, 32);
        run_empty();

        run_class(4, 16, 100, 1);
        run_class(4, 20, 20, 0);
        run_class(1, 33, 33, 0);
        run_class(1, 64, 32, 1);
        run_class(8, 9, 17, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule